// File: doc/BRIEF.md
# Triple-Redundant Iterative AES-128 Encryptor

This block encrypts one 128-bit block under a 128-bit key with the AES-128 cipher. It works one round per clock cycle. The initial key mixing, the round logic and the state register are built three times over. A bitwise two-of-three vote over the three state registers forms the single value that every copy uses for its next round. A fault that upsets one copy for a cycle is therefore outvoted and removed on the following load. It cannot carry through to the result.

The key schedule is computed on the fly and is shared by all three copies. Software or a sequencer presents plaintext and key and pulses `start`. Eleven cycles later it collects the voted ciphertext when `done` pulses. A separate `fault` output reports, cycle by cycle, whether the three copies disagree. It is for logging only and never holds back the result.

Top module: `aesTmrTop`

## Requirements
- R1: While and after synchronous reset (`rst` high), `done` is 0, `cipherOut` is all zeros and `fault` is 0 until the first operation starts.
- R2: For plaintext 00112233445566778899aabbccddeeff and key 000102030405060708090a0b0c0d0e0f, with byte 0 in bits 127:120, the result on `cipherOut` is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: For plaintext 3243f6a8885a308d313198a2e0370734 and key 2b7e151628aed2a6abf7158809cf4f3c, the result is 3925841d02dc09fbdc118597196a0b32.
- R4: Call the rising edge at which `start` is first seen while idle edge 0. Then `done` is high for exactly the one cycle that follows edge 11, and is low otherwise.
- R5: A `start` pulse that arrives while an operation is in progress, carrying other plaintext and key, is ignored: the running result and the timing of `done` are unchanged.
- R6: If one of the three state copies holds a wrong value during a middle round, the ciphertext is still correct.
- R7: `fault` is high in every cycle where the three state copies are not all equal, and low in every cycle of an operation that has no injected fault.
- R8: `cipherOut` changes only on the edge that raises `done`, and holds its value while the block is idle or busy with the next operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins an encryption when the block is idle |
| plainIn | input | 128 | Plaintext block, byte 0 in bits 127:120 |
| keyIn | input | 128 | Cipher key, byte 0 in bits 127:120 |
| cipherOut | output | 128 | Voted ciphertext of the last completed operation |
| done | output | 1 | One-cycle pulse when `cipherOut` has been updated |
| fault | output | 1 | High while the three state copies disagree |

## Verification
The assertions assume that `start` is a level sampled once per cycle. They also assume that plaintext and key matter only on the edge where an idle block accepts `start`. The checker therefore keeps its own busy window and counts edges from the accepted start; it does not rely on the stimulus being spaced out. The stimulus changes inputs only at falling edges. It deliberately raises `start` in the middle of an operation so that the busy window is exercised. Faults are introduced only by overriding a single copy's state register for two edges. That keeps the two-of-three majority intact, which the masking property requires.

// File: rtl/aesTmrPkg.sv
`timescale 1ns/1ps
package aesTmrPkg;
  localparam int BLOCK_W    = 128;
  localparam int BYTE_W     = 8;
  localparam int NUM_BYTES  = BLOCK_W / BYTE_W;
  localparam int NUM_ROUNDS = 10;
  localparam int CNT_W      = $clog2(NUM_ROUNDS + 1);
  localparam int NUM_COPIES = 3;

  typedef struct packed {
    logic loadInit;
    logic runRound;
    logic lastRound;
    logic finish;
  } ctrlStrobes_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 8'h00;
    logic [7:0] sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // substitution: inverse as a^254, then the affine map
  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] pw = a;
    logic [7:0] inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      pw  = gfMul(pw, pw);
      inv = gfMul(inv, pw);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [127:0] majority3(input logic [127:0] a,
                                             input logic [127:0] b,
                                             input logic [127:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [127:0] aesRound(input logic [127:0] s,
                                            input logic [127:0] k,
                                            input logic last);
    logic [127:0] sub, rot, mix;
    logic [7:0] a0, a1, a2, a3;
    for (int i = 0; i < NUM_BYTES; i++)
      sub[127-8*i -: 8] = sbox(s[127-8*i -: 8]);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        rot[127-8*(4*c+r) -: 8] = sub[127-8*(4*((c+r)%4)+r) -: 8];
    for (int c = 0; c < 4; c++) begin
      a0 = rot[127-32*c -: 8];
      a1 = rot[119-32*c -: 8];
      a2 = rot[111-32*c -: 8];
      a3 = rot[103-32*c -: 8];
      mix[127-32*c -: 8] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
      mix[119-32*c -: 8] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
      mix[111-32*c -: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
      mix[103-32*c -: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
    end
    return (last ? rot : mix) ^ k;
  endfunction

  function automatic logic [127:0] expandKey(input logic [127:0] k,
                                             input logic [7:0] rc);
    logic [31:0] w0, w1, w2, w3, t;
    w0 = k[127:96];
    w1 = k[95:64];
    w2 = k[63:32];
    w3 = k[31:0];
    t  = {sbox(w3[23:16]) ^ rc, sbox(w3[15:8]), sbox(w3[7:0]), sbox(w3[31:24])};
    w0 = w0 ^ t;
    w1 = w1 ^ w0;
    w2 = w2 ^ w1;
    w3 = w3 ^ w2;
    return {w0, w1, w2, w3};
  endfunction
endpackage

// File: rtl/aesTmrCtrl.sv
`timescale 1ns/1ps
module aesTmrCtrl
  import aesTmrPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output ctrlStrobes_t ctl,
  output logic         done
);
  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_OUT} phase_t;

  phase_t     phase;
  logic [CNT_W-1:0] roundCnt;

  always_comb begin
    ctl.loadInit  = (phase == PH_IDLE) && start;
    ctl.runRound  = (phase == PH_RUN);
    ctl.lastRound = (phase == PH_RUN) && (roundCnt == CNT_W'(NUM_ROUNDS));
    ctl.finish    = (phase == PH_OUT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      roundCnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= (phase == PH_OUT);
      case (phase)
        PH_IDLE: if (start) begin
          phase    <= PH_RUN;
          roundCnt <= CNT_W'(1);
        end
        PH_RUN: begin
          roundCnt <= roundCnt + CNT_W'(1);
          if (roundCnt == CNT_W'(NUM_ROUNDS)) phase <= PH_OUT;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aesTmrDatapath.sv
`timescale 1ns/1ps
module aesTmrDatapath
  import aesTmrPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       ctl,
  input  logic [BLOCK_W-1:0] plainIn,
  input  logic [BLOCK_W-1:0] keyIn,
  output logic [BLOCK_W-1:0] cipherOut,
  output logic               copiesDiffer
);
  logic [BLOCK_W-1:0] roundKeyQ, nextKey, voted;
  logic [7:0]         rconQ;
  logic [BLOCK_W-1:0] copyQ [NUM_COPIES];

  assign nextKey = expandKey(roundKeyQ, rconQ);

  // shared key schedule
  always_ff @(posedge clk) begin
    if (rst) begin
      roundKeyQ <= '0;
      rconQ     <= 8'h01;
    end else if (ctl.loadInit) begin
      roundKeyQ <= keyIn;
      rconQ     <= 8'h01;
    end else if (ctl.runRound) begin
      roundKeyQ <= nextKey;
      rconQ     <= xtime(rconQ);
    end
  end

  // three independent initial-round, round and state-register copies
  for (genvar i = 0; i < NUM_COPIES; i++) begin : genCopy
    logic [BLOCK_W-1:0] stateQ, initWord, roundWord;
    assign initWord  = plainIn ^ keyIn;
    assign roundWord = aesRound(voted, nextKey, ctl.lastRound);
    always_ff @(posedge clk) begin
      if (rst)               stateQ <= '0;
      else if (ctl.loadInit) stateQ <= initWord;
      else if (ctl.runRound) stateQ <= roundWord;
    end
    assign copyQ[i] = stateQ;
  end

  assign voted        = majority3(copyQ[0], copyQ[1], copyQ[2]);
  assign copiesDiffer = (copyQ[0] != copyQ[1]) || (copyQ[1] != copyQ[2]);

  always_ff @(posedge clk) begin
    if (rst)             cipherOut <= '0;
    else if (ctl.finish) cipherOut <= majority3(copyQ[0], copyQ[1], copyQ[2]);
  end
endmodule

// File: rtl/aesTmrTop.sv
`timescale 1ns/1ps
module aesTmrTop
  import aesTmrPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [BLOCK_W-1:0] plainIn,
  input  logic [BLOCK_W-1:0] keyIn,
  output logic [BLOCK_W-1:0] cipherOut,
  output logic               done,
  output logic               fault
);
  ctrlStrobes_t ctl;

  aesTmrCtrl uCtrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ctl   (ctl),
    .done  (done)
  );

  aesTmrDatapath uDatapath (
    .clk          (clk),
    .rst          (rst),
    .ctl          (ctl),
    .plainIn      (plainIn),
    .keyIn        (keyIn),
    .cipherOut    (cipherOut),
    .copiesDiffer (fault)
  );
endmodule

// File: rtl/aesTmrChecker.sv
`timescale 1ns/1ps
module aesTmrChecker
  import aesTmrPkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [BLOCK_W-1:0] cipherOut,
  input logic               done
);
  logic             busyChk;
  logic [CNT_W-1:0] edgeCnt;
  logic             windowEnd;

  assign windowEnd = busyChk && (edgeCnt == CNT_W'(NUM_ROUNDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      busyChk <= 1'b0;
      edgeCnt <= '0;
    end else if (!busyChk) begin
      if (start) begin
        busyChk <= 1'b1;
        edgeCnt <= '0;
      end
    end else if (windowEnd) begin
      busyChk <= 1'b0;
    end else begin
      edgeCnt <= edgeCnt + CNT_W'(1);
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R4
  AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (rst) windowEnd |=> done); // R4
  AST_DONE_ONLY_ON_TIME: assert property (@(posedge clk) disable iff (rst) done |-> $past(windowEnd)); // R5
  AST_CT_CHANGES_WITH_DONE: assert property (@(posedge clk) disable iff (rst) !$stable(cipherOut) |-> done); // R8
endmodule

bind aesTmrTop aesTmrChecker uChk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .cipherOut (cipherOut),
  .done      (done)
);

// File: tb/sim_aesTmrTop.sv
`timescale 1ns/1ps
module sim_aesTmrTop;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] plainIn = '0;
  logic [127:0] keyIn = '0;
  logic [127:0] cipherOut;
  logic         done, fault;
  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;

  localparam logic [127:0] PT_A  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] KEY_A = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] CT_A  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] PT_B  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] KEY_B = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] CT_B  = 128'h3925841d02dc09fbdc118597196a0b32;

  always #2.5 clk = ~clk;

  aesTmrTop u0 (
    .clk(clk), .rst(rst), .start(start), .plainIn(plainIn), .keyIn(keyIn),
    .cipherOut(cipherOut), .done(done), .fault(fault)
  );

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    nChecks++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one operation; optional start while busy and optional single-copy upset
  task automatic runOp(input logic [127:0] pt, input logic [127:0] key,
                       input logic [127:0] expCt, input string req,
                       input bit busyStart, input bit inject);
    @(negedge clk);
    plainIn = pt;
    keyIn   = key;
    start   = 1'b1;
    for (int k = 0; k <= 12; k++) begin
      @(negedge clk);
      if (k == 0) start = 1'b0;
      if (busyStart && k == 4) begin
        start   = 1'b1;
        plainIn = ~pt;
        keyIn   = ~key;
      end
      if (busyStart && k == 5) start = 1'b0;
      if (inject && k == 5) begin
        force u0.uDatapath.genCopy[1].stateQ = 128'hdeadbeef_0badf00d_5a5a5a5a_c3c3c3c3;
        #1;
        check("R7 fault raised by upset copy", {127'd0, fault}, 128'd1);
      end
      if (inject && k == 6) release u0.uDatapath.genCopy[1].stateQ;
      check({"R4 done timing ", req}, {127'd0, done}, {127'd0, (k == 11)});
      if (!inject) check({"R7 no fault ", req}, {127'd0, fault}, 128'd0);
      else if (k >= 7) check("R6 upset copy repaired", {127'd0, fault}, 128'd0);
      if (k == 11) check(req, cipherOut, expCt);
    end
    check({"R8 result held ", req}, cipherOut, expCt);
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done in reset", {127'd0, done}, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done after reset", {127'd0, done}, 128'd0);
    check("R1 cipher after reset", cipherOut, 128'd0);
    check("R1 fault after reset", {127'd0, fault}, 128'd0);
  endtask

  task automatic testVectorA();
    runOp(PT_A, KEY_A, CT_A, "R2 vector A", 1'b0, 1'b0);
  endtask

  task automatic testVectorB();
    runOp(PT_B, KEY_B, CT_B, "R3 vector B", 1'b0, 1'b0);
  endtask

  task automatic testBusyStart();
    runOp(PT_A, KEY_A, CT_A, "R5 start while busy", 1'b1, 1'b0);
  endtask

  task automatic testFaultMask();
    runOp(PT_B, KEY_B, CT_B, "R6 masked upset", 1'b0, 1'b1);
  endtask

  task automatic testHold();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      plainIn = {4{k[31:0]}};
      keyIn   = ~plainIn;
      check("R8 idle hold", cipherOut, CT_B);
      check("R8 no done while idle", {127'd0, done}, 128'd0);
    end
  endtask

  initial begin
    testReset();
    testVectorA();
    testVectorB();
    testBusyStart();
    testFaultMask();
    testHold();
    testVectorA();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule